// File: doc/BRIEF.md
# Single-Clock FIFO with Programmable Level Flags

This block is a single-clock FIFO of 9-bit words. Its depth is a power-of-two parameter between 256 and 4096. Data leaves through a registered output that changes only when a read takes place.

Four active-low status flags are produced. Two are fixed: empty and full. Two are programmable: almost-empty and almost-full. The almost-empty threshold `n` and the almost-full threshold `m` arrive as inputs from a neighbouring offset-register block, which holds them at 7 until software programs them.

One write-control pin has two uses. Its level while reset is held selects how it works for the rest of that run:
- **Dual-enable mode:** the pin is a second, active-high write enable.
- **Programmable-flag mode:** the pin is an active-low load select. While load is low, write and read attempts become strobes to the offset-register block instead of FIFO traffic. An offset read copies the value that block presents into the output register.

Top module: `sfifo_pflag`

## Requirements
- R1: While `rst_n` is low at a rising edge, the FIFO empties. After that edge `empty_n`=0, `almost_empty_n`=0, `full_n`=1, `almost_full_n`=1 and `rd_data`=0. This holds even if the FIFO held data before the reset.
- R2: The level of `wr_en2_ld` at the last rising edge with `rst_n` low sets the mode: 1 selects dual-enable mode and 0 selects programmable-flag mode. Later changes of that pin never change the mode. In dual-enable mode, a low `wr_en2_ld` blocks writing and produces no offset strobe.
- R3: In dual-enable mode, a word is stored at a rising edge only when `wr_en1_n`=0 and `wr_en2_ld`=1.
- R4: In programmable-flag mode with `wr_en2_ld`=1, `wr_en1_n`=0 alone stores a word at each rising edge.
- R5: A FIFO read takes place at a rising edge only when both `rd_en1_n` and `rd_en2_n` are 0. The read places the oldest stored word in `rd_data`. Otherwise `rd_data` keeps its value.
- R6: Write attempts have no effect while `full_n` is 0, and read attempts have no effect while `empty_n` is 0.
- R7: With occupancy `c`, `empty_n` is 0 exactly when `c`=0, and `almost_empty_n` is 0 exactly when `c` <= `empty_lvl`.
- R8: `full_n` is 0 exactly when `c` equals DEPTH, and `almost_full_n` is 0 exactly when `c` >= DEPTH - `full_lvl`.
- R9: In programmable-flag mode with `wr_en2_ld`=0:
  - `wr_en1_n`=0 raises `ofs_wr_stb` in that cycle and stores nothing.
  - `rd_en1_n`=`rd_en2_n`=0 raises `ofs_rd_stb`, moves no FIFO data, and loads `ofs_rdata` into `rd_data` at that edge.
- R10: A read and a write accepted at the same edge leave the occupancy unchanged and keep first-in first-out order.
- R11: All four flags are registers. They reflect the occupancy that results from the operations at a rising edge, using the thresholds present at that edge, immediately after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en1_n | input | 1 | Primary write enable, active low |
| wr_en2_ld | input | 1 | Second write enable (high) or offset load select (low); its level during reset picks the mode |
| rd_en1_n | input | 1 | First read enable, active low |
| rd_en2_n | input | 1 | Second read enable, active low |
| wr_data | input | DW | Word to store |
| empty_lvl | input | AW | Almost-empty threshold n |
| full_lvl | input | AW | Almost-full threshold m |
| ofs_rdata | input | DW | Value presented by the offset-register block for an offset read |
| rd_data | output | DW | Registered output word |
| empty_n | output | 1 | Low when no word is stored |
| almost_empty_n | output | 1 | Low when occupancy <= n |
| full_n | output | 1 | Low when occupancy equals DEPTH |
| almost_full_n | output | 1 | Low when occupancy >= DEPTH - m |
| ofs_wr_stb | output | 1 | Offset write strobe for the current cycle |
| ofs_rd_stb | output | 1 | Offset read strobe for the current cycle |

## Verification
Two pairs of functions can meet in one cycle.
- **Read and write at a boundary:** a read and a write are driven together at occupancy 0 and at occupancy DEPTH. At 0 only the write may take effect; at DEPTH only the read may. The run is judged on the flags and on the order of the words that later appear.
- **Offset access and FIFO traffic:** in programmable-flag mode, the load select is toggled at random while write and read enables are active. Every strobe, flag and output word is compared on each clock against a queue-based model.

Thresholds are changed during traffic, so that a flag update driven by a new threshold and one driven by an occupancy step can land on the same edge.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  typedef enum logic {
    MODE_DUAL_WE = 1'b0,
    MODE_PFLAG   = 1'b1
  } wmode_e;
endpackage

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
  import sfifo_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wen1_n,
  input  logic   wen2_ld,
  input  logic   ren1_n,
  input  logic   ren2_n,
  input  logic   full_n,
  input  logic   empty_n,
  output wmode_e mode,
  output logic   wr_fire,
  output logic   rd_fire,
  output logic   ofs_wr,
  output logic   ofs_rd
);
  logic ld_sel;
  logic wr_req;
  logic rd_req;

  // mode follows the pin only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) mode <= wen2_ld ? MODE_DUAL_WE : MODE_PFLAG;
  end

  always_comb begin
    ld_sel  = (mode == MODE_PFLAG) && !wen2_ld;
    wr_req  = !wen1_n && wen2_ld;
    rd_req  = !ren1_n && !ren2_n && !ld_sel;
    wr_fire = rst_n && wr_req && full_n;
    rd_fire = rst_n && rd_req && empty_n;
    ofs_wr  = rst_n && ld_sel && !wen1_n;
    ofs_rd  = rst_n && ld_sel && !ren1_n && !ren2_n;
  end

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode));
endmodule

// File: rtl/sfifo_ram.sv
module sfifo_ram #(
  parameter int DEPTH = 256,
  parameter int DW    = 9,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_fire,
  input  logic          rd_fire,
  input  logic          ofs_rd,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] ofs_rdata,
  output logic [DW-1:0] dout,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr
);
  logic [DW-1:0] mem [DEPTH];

  // array port kept free of reset so it maps onto block memory
  always_ff @(posedge clk) begin
    if (wr_fire) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr_fire) wptr <= wptr + 1'b1;
      if (rd_fire) rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       dout <= '0;
    else if (rd_fire) dout <= mem[rptr];
    else if (ofs_rd)  dout <= ofs_rdata;
  end
endmodule

// File: rtl/sfifo_flags.sv
module sfifo_flags #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_fire,
  input  logic          rd_fire,
  input  logic [AW-1:0] ae_lvl,
  input  logic [AW-1:0] af_lvl,
  output logic [CW-1:0] cnt,
  output logic          empty_n,
  output logic          ae_n,
  output logic          full_n,
  output logic          af_n
);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [CW-1:0] cnt_d;
  logic [CW-1:0] af_limit;

  always_comb begin
    cnt_d = cnt;
    if (wr_fire && !rd_fire)      cnt_d = cnt + 1'b1;
    else if (!wr_fire && rd_fire) cnt_d = cnt - 1'b1;
    af_limit = FULLC - {1'b0, af_lvl};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      empty_n <= 1'b0;
      ae_n    <= 1'b0;
      full_n  <= 1'b1;
      af_n    <= 1'b1;
    end else begin
      cnt     <= cnt_d;
      empty_n <= (cnt_d != '0);
      ae_n    <= (cnt_d > {1'b0, ae_lvl});
      full_n  <= (cnt_d != FULLC);
      af_n    <= (cnt_d < af_limit);
    end
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULLC);
  // R7
  empty_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty_n == (cnt != '0));
  // R8
  full_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_n == (cnt != FULLC));
  // R11
  flag_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !rd_fire) |=> empty_n);
endmodule

// File: rtl/sfifo_pflag.sv
module sfifo_pflag
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DW    = 9,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en1_n,
  input  logic          wr_en2_ld,
  input  logic          rd_en1_n,
  input  logic          rd_en2_n,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] empty_lvl,
  input  logic [AW-1:0] full_lvl,
  input  logic [DW-1:0] ofs_rdata,
  output logic [DW-1:0] rd_data,
  output logic          empty_n,
  output logic          almost_empty_n,
  output logic          full_n,
  output logic          almost_full_n,
  output logic          ofs_wr_stb,
  output logic          ofs_rd_stb
);
  wmode_e        mode;
  logic          wr_fire;
  logic          rd_fire;
  logic [AW-1:0] wptr;
  logic [AW-1:0] rptr;
  logic [AW:0]   cnt;

  sfifo_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wen1_n  (wr_en1_n),
    .wen2_ld (wr_en2_ld),
    .ren1_n  (rd_en1_n),
    .ren2_n  (rd_en2_n),
    .full_n  (full_n),
    .empty_n (empty_n),
    .mode    (mode),
    .wr_fire (wr_fire),
    .rd_fire (rd_fire),
    .ofs_wr  (ofs_wr_stb),
    .ofs_rd  (ofs_rd_stb)
  );

  sfifo_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_fire   (wr_fire),
    .rd_fire   (rd_fire),
    .ofs_rd    (ofs_rd_stb),
    .din       (wr_data),
    .ofs_rdata (ofs_rdata),
    .dout      (rd_data),
    .wptr      (wptr),
    .rptr      (rptr)
  );

  sfifo_flags #(.DEPTH(DEPTH)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (wr_fire),
    .rd_fire (rd_fire),
    .ae_lvl  (empty_lvl),
    .af_lvl  (full_lvl),
    .cnt     (cnt),
    .empty_n (empty_n),
    .ae_n    (almost_empty_n),
    .full_n  (full_n),
    .af_n    (almost_full_n)
  );

  // R10
  ptr_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt[AW-1:0] == AW'(wptr - rptr));
  // R9
  ofs_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_wr_stb |=> $stable(wptr));
endmodule

// File: tb/test_sfifo_pflag.sv
`timescale 1ns/1ps
module test_sfifo_pflag;
  localparam int DEPTH = 256;
  localparam int DW    = 9;
  localparam int AW    = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en1_n = 1'b1, wr_en2_ld = 1'b1, rd_en1_n = 1'b1, rd_en2_n = 1'b1;
  logic [DW-1:0] wr_data = '0, ofs_rdata = '0;
  logic [AW-1:0] empty_lvl = 8'd7, full_lvl = 8'd7;
  logic [DW-1:0] rd_data;
  logic          empty_n, almost_empty_n, full_n, almost_full_n, ofs_wr_stb, ofs_rd_stb;

  int    compared = 0;
  int    mismatched = 0;
  bit    done = 1'b0;
  string phase = "R1 reset";

  int q[$];
  int exp_dout = 0;
  bit exp_e = 0, exp_ae = 0, exp_f = 1, exp_af = 1;
  bit mode_pf = 0;

  always #5 clk = ~clk;

  sfifo_pflag #(.DEPTH(DEPTH), .DW(DW)) i_sfifo_pflag (
    .clk(clk), .rst_n(rst_n), .wr_en1_n(wr_en1_n), .wr_en2_ld(wr_en2_ld),
    .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n), .wr_data(wr_data),
    .empty_lvl(empty_lvl), .full_lvl(full_lvl), .ofs_rdata(ofs_rdata),
    .rd_data(rd_data), .empty_n(empty_n), .almost_empty_n(almost_empty_n),
    .full_n(full_n), .almost_full_n(almost_full_n),
    .ofs_wr_stb(ofs_wr_stb), .ofs_rd_stb(ofs_rd_stb)
  );

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s (%s) t=%0t actual=%0d expected=%0d", tag, phase, $time, act, exp);
    end
  endtask

  // one clock: called at a falling edge, returns at the next falling edge
  task automatic cyc(input bit w1, input bit ld, input bit r1, input bit r2, input int d);
    bit pf_sel, ow, orr, do_w, do_r;
    int sz;
    wr_en1_n = w1; wr_en2_ld = ld; rd_en1_n = r1; rd_en2_n = r2; wr_data = d[DW-1:0];
    pf_sel = mode_pf && !ld;
    ow  = rst_n && pf_sel && !w1;
    orr = rst_n && pf_sel && !r1 && !r2;
    #1;
    chk("R9 ofs_wr_stb", int'(ofs_wr_stb), int'(ow));
    chk("R9 ofs_rd_stb", int'(ofs_rd_stb), int'(orr));
    if (!rst_n) begin
      q.delete();
      exp_dout = 0;
      mode_pf = !ld;
    end else begin
      do_w = !w1 && ld && (q.size() < DEPTH);
      do_r = !r1 && !r2 && !pf_sel && (q.size() > 0);
      if (do_r) exp_dout = q.pop_front();
      else if (orr) exp_dout = int'(ofs_rdata);
      if (do_w) q.push_back(d & 9'h1FF);
    end
    sz = q.size();
    if (!rst_n) begin
      exp_e = 0; exp_ae = 0; exp_f = 1; exp_af = 1;
    end else begin
      exp_e  = (sz != 0);
      exp_ae = (sz > int'(empty_lvl));
      exp_f  = (sz != DEPTH);
      exp_af = (sz < DEPTH - int'(full_lvl));
    end
    @(posedge clk);
    @(negedge clk);
    chk("R5 rd_data", int'(rd_data), exp_dout);
    chk("R7 empty_n", int'(empty_n), int'(exp_e));
    chk("R7 almost_empty_n", int'(almost_empty_n), int'(exp_ae));
    chk("R8 full_n", int'(full_n), int'(exp_f));
    chk("R8 almost_full_n", int'(almost_full_n), int'(exp_af));
  endtask

  task automatic do_reset(input bit ld);
    rst_n = 1'b0;
    cyc(1, ld, 1, 1, 0);
    cyc(1, ld, 1, 1, 0);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    @(negedge clk);
    phase = "R1 reset, dual-enable mode";
    do_reset(1'b1);

    phase = "R3 dual-enable writes";
    for (int i = 0; i < 10; i++) cyc(0, 1, 1, 1, i + 1);
    phase = "R2 dual-enable pin low blocks write";
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 1, 300 + i);
    phase = "R5 single read enable holds output";
    cyc(1, 1, 0, 1, 0);
    cyc(1, 1, 1, 0, 0);
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, 0);

    phase = "R10 simultaneous read and write";
    for (int i = 0; i < 20; i++) cyc(0, 1, 0, 0, 100 + i);

    phase = "R8 fill past full";
    for (int i = 0; i < DEPTH + 5; i++) cyc(0, 1, 1, 1, (i * 7) & 511);
    phase = "R6 read and write at full";
    cyc(0, 1, 0, 0, 77);
    cyc(0, 1, 1, 1, 78);
    phase = "R7 drain past empty";
    for (int i = 0; i < DEPTH + 5; i++) cyc(1, 1, 0, 0, 0);
    phase = "R6 read and write at empty";
    cyc(0, 1, 0, 0, 55);
    cyc(1, 1, 0, 0, 0);

    phase = "R11 changed thresholds";
    empty_lvl = 8'd20; full_lvl = 8'd30;
    for (int i = 0; i < DEPTH - 20; i++) cyc(0, 1, 1, 1, i);
    empty_lvl = 8'd0; full_lvl = 8'd0;
    cyc(1, 1, 1, 1, 0);
    for (int i = 0; i < DEPTH - 20; i++) cyc(1, 1, 0, 0, 0);

    phase = "R1 reset with data, programmable-flag mode";
    empty_lvl = 8'd7; full_lvl = 8'd7;
    for (int i = 0; i < 5; i++) cyc(0, 1, 1, 1, 200 + i);
    do_reset(1'b0);

    phase = "R4 programmable-flag mode writes";
    for (int i = 0; i < 6; i++) cyc(0, 1, 1, 1, 400 + i);
    phase = "R9 offset writes and reads";
    ofs_rdata = 9'h0A5;
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 1, 9 + i);
    cyc(1, 0, 0, 0, 0);
    ofs_rdata = 9'h13C;
    cyc(1, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 33);

    phase = "R2 mode held under random traffic (R11)";
    for (int i = 0; i < 3000; i++) begin
      if (i % 400 == 0) begin
        empty_lvl = AW'($urandom_range(0, 255));
        full_lvl  = AW'($urandom_range(0, 255));
      end
      ofs_rdata = DW'($urandom_range(0, 511));
      cyc($urandom_range(0, 2) == 0, $urandom_range(0, 4) != 0,
          $urandom_range(0, 2) != 0, $urandom_range(0, 3) == 0,
          int'($urandom_range(0, 511)));
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule